// File: doc/BRIEF.md
# Dual-Field Serial Voice Highway Port

This block is the serial edge of a telephone line interface. It runs on a 2.048 MHz data clock with an 8 kHz frame sync, which gives 256 clock periods per frame. Each frame carries two byte-wide fields in each direction, and the two edges of frame sync place them in time. A rising edge opens the voice field. In that field a voice sample is sent and a voice sample is received. A falling edge opens the second field. In that field a supervision/status byte is sent and a control byte is received.

The transmit line is driven only during its two 8-bit fields and floats at all other times. A separate drive indicator goes high while the line carries data and floats otherwise. Received bytes are handed to the codec core and the supervision logic on parallel ports, each with a one-cycle valid strobe. Transmit bytes are taken from parallel inputs at the frame edge that opens their field.

Initialisation is qualified. The reset input must be held low for at least `RST_MIN` clocks and then released before state is cleared. While reset is low the transmit side is held disabled.

Top module: `pcm_hwy_port`

## Requirements
- R1: A rising frame-sync edge seen at a data-clock rising edge captures `tx_voice_byte` at that edge. In the 8 following clock periods `ser_tx` carries that byte, most significant bit first. Changes to `tx_voice_byte` after the capturing edge have no effect on the field.
- R2: A falling frame-sync edge captures `tx_sup_byte` in the same way. It sends that byte on `ser_tx`, most significant bit first, over the 8 following clock periods.
- R3: In both fields `ser_rx` is sampled on the falling data-clock edge of each of the 8 periods that follow the frame edge, first bit most significant. The byte appears on `rx_voice_byte` (rising-edge field) or `rx_ctl_byte` (falling-edge field) in the period after the eighth bit. A one-period strobe on `rx_voice_vld` or `rx_ctl_vld` marks it. The byte is held until the next completion.
- R4: `ser_tx_drv` reads 1 exactly in the periods where `ser_tx` carries a field bit and is high-impedance otherwise. At most one field drives at any time.
- R5: A frame edge that arrives while the other field is still in progress ends that field at once and starts the new one. An aborted receive field produces no strobe and leaves its held byte unchanged.
- R6: While `rst_n` is low, `ser_tx_drv` is not driven high from the next period on, no valid strobe is raised and frame edges start no field.
- R7: A low phase of `rst_n` that lasts at least `RST_MIN` clocks, followed by a high level, clears both received bytes to 0 in the period after release. A shorter low phase leaves both received bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock, 2.048 MHz |
| rst_n | input | 1 | Active-low reset, synchronous, qualified by length |
| frm_sync | input | 1 | 8 kHz frame sync; both edges open a field |
| ser_rx | input | 1 | Serial receive data |
| tx_voice_byte | input | BYTE_W | Voice byte to send in the rising-edge field |
| tx_sup_byte | input | BYTE_W | Supervision/status byte to send in the falling-edge field |
| ser_tx | output | 1 | Serial transmit data, high-impedance outside the fields |
| ser_tx_drv | output | 1 | High while `ser_tx` is driven, high-impedance otherwise |
| rx_voice_byte | output | BYTE_W | Last complete received voice byte |
| rx_voice_vld | output | 1 | One-period strobe on a new voice byte |
| rx_ctl_byte | output | BYTE_W | Last complete received control byte |
| rx_ctl_vld | output | 1 | One-period strobe on a new control byte |

## Verification
The bench builds the block with its defaults, `BYTE_W` = 8 and `RST_MIN` = 4. These defaults keep the reset threshold small enough to test a low phase just below it and one just above it.

The bench drives frame sync with high and low phases far shorter than the 256-period frame. High and low phases of 8 to 30 periods pack many fields into the run. Directed phases of 3 and 5 periods reach the abort path, where one field cuts short the other. Parallel bytes change every period, so the bench can show that each transmit byte is taken only at its opening edge.

// File: rtl/hwy_pkg.sv
// Shared definitions for the serial voice highway port.
// Assumes: exactly two fields per frame, indexed by the frame-sync edge that opens them.
package hwy_pkg;
    localparam int unsigned NUM_FIELDS = 2;

    typedef enum logic [0:0] {
        FLD_VOICE = 1'b0,   // opened by the rising frame-sync edge
        FLD_CTRL  = 1'b1    // opened by the falling frame-sync edge
    } field_e;
endpackage

// File: rtl/hwy_rst_qual.sv
// Reset qualifier: counts clocks with rst_n low and issues a one-cycle
// init pulse on release only if the low phase lasted RST_MIN clocks or more.
// Assumes: rst_n is synchronous to clk. The hold output mirrors the low level.
module hwy_rst_qual #(
    parameter int unsigned RST_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold,
    output logic init
);
    localparam int unsigned CW = $clog2(RST_MIN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(RST_MIN);

    logic [CW-1:0] low_cnt;

    // Saturating count of low clocks; cleared once rst_n is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assign hold = !rst_n;
    assign init = rst_n && (low_cnt == CNT_TOP);
endmodule

// File: rtl/hwy_fs_edge.sv
// Frame-sync edge detector in the data clock domain.
// Assumes: frame sync is stable around the rising data clock edge.
module hwy_fs_edge (
    input  logic clk,
    input  logic fs,
    output logic rise,
    output logic fall
);
    logic fs_q;

    // Previous frame-sync level for edge comparison.
    always_ff @(posedge clk) begin
        fs_q <= fs;
    end

    assign rise = fs && !fs_q;
    assign fall = !fs && fs_q;
endmodule

// File: rtl/hwy_slot.sv
// One W-bit field engine. It shifts out a byte captured at start, MSB first,
// over W periods, and shifts in W received bits, then strobes the complete byte.
// Assumes: start and abort are one-cycle pulses. clr and hold override start.
module hwy_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         hold,
    input  logic         clr,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] tx_byte,
    input  logic         rx_bit,
    output logic         tx_on,
    output logic         tx_bit,
    output logic [W-1:0] rx_byte,
    output logic         rx_stb
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] tx_cnt;
    logic [W-1:0]  tx_sh;
    logic          rx_on;
    logic [CW-1:0] rx_cnt;
    logic [W-2:0]  rx_sh;
    logic          rx_done;

    // Transmit shifter: load at start, shift each period, stop after W bits.
    always_ff @(posedge clk) begin
        if (clr || hold) begin
            tx_on  <= 1'b0;
            tx_cnt <= '0;
            tx_sh  <= '0;
        end else if (start) begin
            tx_on  <= 1'b1;
            tx_cnt <= '0;
            tx_sh  <= tx_byte;
        end else if (abort) begin
            tx_on  <= 1'b0;
        end else if (tx_on) begin
            if (tx_cnt == LAST) begin
                tx_on <= 1'b0;
            end else begin
                tx_cnt <= tx_cnt + 1'b1;
                tx_sh  <= {tx_sh[W-2:0], 1'b0};
            end
        end
    end

    assign tx_bit  = tx_sh[W-1];
    assign rx_done = rx_on && (rx_cnt == LAST) && !start && !abort && !hold && !clr;

    // Receive counter and strobe: W shifts after start, strobe on the last.
    always_ff @(posedge clk) begin
        if (clr || hold) begin
            rx_on  <= 1'b0;
            rx_cnt <= '0;
            rx_stb <= 1'b0;
        end else begin
            rx_stb <= rx_done;
            if (start) begin
                rx_on  <= 1'b1;
                rx_cnt <= '0;
            end else if (abort || rx_done) begin
                rx_on  <= 1'b0;
            end else if (rx_on) begin
                rx_cnt <= rx_cnt + 1'b1;
            end
        end
    end

    // Receive data path: shift bits in MSB first while active.
    always_ff @(posedge clk) begin
        if (rx_on) rx_sh <= (W-1)'({rx_sh, rx_bit});
    end

    // Held output byte: cleared only by a qualified init.
    always_ff @(posedge clk) begin
        if (clr)          rx_byte <= '0;
        else if (rx_done) rx_byte <= {rx_sh, rx_bit};
    end

    // R1 R2: a start outside reset opens both shifters in the next period
    start_opens_chk: assert property (@(posedge clk) disable iff (hold || clr)
        start |=> (tx_on && rx_on));

    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (hold || clr)
        rx_stb |=> !rx_stb);

    // R5
    abort_stops_chk: assert property (@(posedge clk) disable iff (hold || clr)
        (abort && !start) |=> (!tx_on && !rx_stb));
endmodule

// File: rtl/pcm_hwy_port.sv
// Dual-field serial highway port. The rising frame-sync edge opens the voice
// field and the falling edge opens the control/status field. ser_tx and
// ser_tx_drv float outside the fields.
// Assumes: frm_sync and ser_rx change away from the data clock edges, and each
// frame-sync phase is normally at least BYTE_W periods long.
module pcm_hwy_port #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned RST_MIN = 4
) (
    input  logic              dclk,
    input  logic              rst_n,
    input  logic              frm_sync,
    input  logic              ser_rx,
    input  logic [BYTE_W-1:0] tx_voice_byte,
    input  logic [BYTE_W-1:0] tx_sup_byte,
    output logic              ser_tx,
    output logic              ser_tx_drv,
    output logic [BYTE_W-1:0] rx_voice_byte,
    output logic              rx_voice_vld,
    output logic [BYTE_W-1:0] rx_ctl_byte,
    output logic              rx_ctl_vld
);
    import hwy_pkg::*;

    localparam int unsigned NF = NUM_FIELDS;
    localparam int unsigned IV = int'(FLD_VOICE);
    localparam int unsigned IC = int'(FLD_CTRL);

    logic              hold, init;
    logic              fs_rise, fs_fall;
    logic              rx_neg;
    logic [NF-1:0]     f_start, f_abort, f_on, f_bit, f_stb;
    logic [BYTE_W-1:0] f_txb [NF];
    logic [BYTE_W-1:0] f_rxb [NF];
    logic              drive, drive_bit;

    hwy_rst_qual #(.RST_MIN(RST_MIN)) u_rst (
        .clk(dclk), .rst_n(rst_n), .hold(hold), .init(init)
    );

    hwy_fs_edge u_fs (
        .clk(dclk), .fs(frm_sync), .rise(fs_rise), .fall(fs_fall)
    );

    // Receive sample on the falling data clock edge.
    always_ff @(negedge dclk) begin
        rx_neg <= ser_rx;
    end

    assign f_start[IV] = fs_rise;
    assign f_start[IC] = fs_fall;
    assign f_txb[IV]   = tx_voice_byte;
    assign f_txb[IC]   = tx_sup_byte;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        // The other field's opening edge cuts this one short.
        assign f_abort[g] = f_start[NF-1-g];

        hwy_slot #(.W(BYTE_W)) u_slot (
            .clk(dclk), .hold(hold), .clr(init),
            .start(f_start[g]), .abort(f_abort[g]),
            .tx_byte(f_txb[g]), .rx_bit(rx_neg),
            .tx_on(f_on[g]), .tx_bit(f_bit[g]),
            .rx_byte(f_rxb[g]), .rx_stb(f_stb[g])
        );
    end

    assign drive      = |f_on;
    assign drive_bit  = f_on[IC] ? f_bit[IC] : f_bit[IV];
    assign ser_tx     = drive ? drive_bit : 1'bz;
    assign ser_tx_drv = drive ? 1'b1 : 1'bz;

    assign rx_voice_byte = f_rxb[IV];
    assign rx_voice_vld  = f_stb[IV];
    assign rx_ctl_byte   = f_rxb[IC];
    assign rx_ctl_vld    = f_stb[IC];

    // R4
    one_driver_chk: assert property (@(posedge dclk) disable iff (init)
        $onehot0(f_on));

    // R6
    hold_quiet_chk: assert property (@(posedge dclk) disable iff (init)
        !rst_n |=> (!drive && f_stb == '0));

    // R3
    strobe_excl_chk: assert property (@(posedge dclk) disable iff (init || hold)
        $onehot0(f_stb));
endmodule

// File: tb/sim_pcm_hwy_port.sv
module sim_pcm_hwy_port;
    localparam int W    = 8;
    localparam int RMIN = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0, frm_sync = 1'b0, ser_rx = 1'b0;
    logic [W-1:0] tx_voice_byte = '0, tx_sup_byte = '0;
    wire          ser_tx, ser_tx_drv;
    logic [W-1:0] rx_voice_byte, rx_ctl_byte;
    logic         rx_voice_vld, rx_ctl_vld;

    always #2 clk = ~clk;

    pcm_hwy_port #(.BYTE_W(W), .RST_MIN(RMIN)) u0 (
        .dclk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .ser_rx(ser_rx),
        .tx_voice_byte(tx_voice_byte), .tx_sup_byte(tx_sup_byte),
        .ser_tx(ser_tx), .ser_tx_drv(ser_tx_drv),
        .rx_voice_byte(rx_voice_byte), .rx_voice_vld(rx_voice_vld),
        .rx_ctl_byte(rx_ctl_byte), .rx_ctl_vld(rx_ctl_vld)
    );

    int vectors = 0, miscompares = 0;
    int cyc = 0;
    int last_start = -1000;
    bit lkind = 1'b0;              // 0 voice, 1 control
    logic [W-1:0] cap = '0, rxacc = '0, exp_v = '0, exp_c = '0;
    bit pend_v = 0, pend_c = 0;
    bit fs_prev = 0;
    int low_cnt = 0;
    int abort_at = -1000;
    bit done = 0;

    function automatic string fld_req(bit kind);
        return kind ? "R2" : "R1";
    endfunction

    task automatic fail(string req, string what, int act, int exp);
        miscompares++;
        $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    endtask

    // Compare all outputs against the model state for this period.
    task automatic check_outputs();
        int d = cyc - last_start;
        bit en = (d >= 1) && (d <= W);
        string tag = (cyc - abort_at <= W + 1) ? "R5" : "R4";
        vectors++;
        if ((ser_tx_drv === 1'b1) != en) fail(tag, "drive", int'(ser_tx_drv === 1'b1), int'(en));
        if (en && (ser_tx !== cap[W-d])) fail(fld_req(lkind), "tx bit", int'(ser_tx), int'(cap[W-d]));
        if (rx_voice_vld !== pend_v) fail("R3", "voice strobe", int'(rx_voice_vld), int'(pend_v));
        if (rx_ctl_vld !== pend_c) fail("R3", "ctl strobe", int'(rx_ctl_vld), int'(pend_c));
        if (rx_voice_byte !== exp_v) fail("R3", "voice byte", int'(rx_voice_byte), int'(exp_v));
        if (rx_ctl_byte !== exp_c) fail("R3", "ctl byte", int'(rx_ctl_byte), int'(exp_c));
    endtask

    // Advance the model by the inputs applied in this period.
    task automatic update(logic rn, logic fsv, logic rxb, logic [W-1:0] vb, logic [W-1:0] sb);
        int d = cyc - last_start;
        bit st;
        pend_v = 0;
        pend_c = 0;
        if (!rn) begin
            if (low_cnt < RMIN) low_cnt++;
            last_start = -1000;                    // R6 hold
        end else if (low_cnt >= RMIN) begin
            low_cnt = 0;                           // R7 qualified init
            exp_v = '0;
            exp_c = '0;
            last_start = -1000;
        end else begin
            low_cnt = 0;
            st = (fsv != fs_prev);
            if (d >= 1 && d <= W && !st) begin
                rxacc = {rxacc[W-2:0], rxb};
                if (d == W) begin
                    if (lkind) begin pend_c = 1; exp_c = rxacc; end
                    else begin pend_v = 1; exp_v = rxacc; end
                end
            end
            if (st) begin
                if (d >= 1 && d <= W) abort_at = cyc;
                last_start = cyc;
                lkind = !fsv;
                cap = fsv ? vb : sb;
            end
        end
        fs_prev = fsv;
    endtask

    task automatic step(logic rn, logic fsv);
        logic rb;
        logic [W-1:0] vb, sb;
        @(posedge clk);
        #1;
        rb = 1'($urandom);
        vb = W'($urandom);
        sb = W'($urandom);
        rst_n = rn; frm_sync = fsv; ser_rx = rb;
        tx_voice_byte = vb; tx_sup_byte = sb;
        #2;
        check_outputs();
        update(rn, fsv, rb, vb, sb);
        cyc++;
    endtask

    task automatic phase(logic fsv, int n);
        for (int i = 0; i < n; i++) step(1'b1, fsv);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        phase(1'b0, 3);
        // R7 reset state: both held bytes cleared after qualified release
        vectors++;
        if (rx_voice_byte !== '0 || rx_ctl_byte !== '0)
            fail("R7", "reset bytes", int'({rx_voice_byte, rx_ctl_byte}), 0);
        // R1 R2 R3: random frames with legal phase lengths
        for (int f = 0; f < 60; f++) begin
            phase(1'b1, 8 + int'($urandom % 23));
            phase(1'b0, 8 + int'($urandom % 23));
        end
        // R5: short high phase, the falling edge aborts the voice field
        phase(1'b1, 3);
        phase(1'b0, 12);
        // R5: short low phase, the rising edge aborts the control field
        phase(1'b1, 10);
        phase(1'b0, 5);
        phase(1'b1, 12);
        phase(1'b0, 12);
        // R6: reset low in the middle of a field
        phase(1'b1, 3);
        for (int i = 0; i < RMIN - 2; i++) step(1'b0, 1'b1);
        phase(1'b1, 12);
        phase(1'b0, 12);
        // R7: short low keeps held bytes; ensure they are nonzero first
        for (int t = 0; t < 20 && (exp_c == '0 || exp_v == '0); t++) begin
            phase(1'b1, 10);
            phase(1'b0, 10);
        end
        for (int i = 0; i < RMIN - 1; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        vectors++;
        if (rx_ctl_byte === '0 && exp_c !== '0)
            fail("R7", "short low cleared ctl", int'(rx_ctl_byte), int'(exp_c));
        // R7: long low clears
        for (int i = 0; i < RMIN + 2; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        vectors++;
        if (rx_voice_byte !== '0 || rx_ctl_byte !== '0)
            fail("R7", "long low bytes", int'({rx_voice_byte, rx_ctl_byte}), 0);
        // more random frames, including occasional short phases
        for (int f = 0; f < 80; f++) begin
            phase(1'b1, ($urandom % 8 == 0) ? 2 + int'($urandom % 6) : 8 + int'($urandom % 23));
            phase(1'b0, ($urandom % 8 == 0) ? 2 + int'($urandom % 6) : 8 + int'($urandom % 23));
        end
        phase(1'b0, 12);
        finish_run();
    end
endmodule